// File: doc/BRIEF.md
# Selectable External Event Counter

This block counts pulses arriving on one of two external lines that have no timing relationship to the system clock. Each line is first brought into the system clock domain through its own two-stage synchronizer. Only after that does a select input pick one of the two synchronized levels. A rising-edge detector turns the picked level into a one-cycle count enable, which lets a binary counter advance by one on the next system clock edge. Neither external line, nor any mux of them, ever reaches the clock pin of a flip-flop.

A host sets the select to choose the event source, pulses the clear input to restart from zero, and reads the count in parallel in the system clock domain. Changing the select never produces a count by itself, even when the newly chosen line is already high.

Top module: `evc_event_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0 after that edge.
- R2: A rising level on the selected line, applied between two system clock edges, raises `count` by one after the third following rising clock edge and not earlier (two synchronizer stages, then the registered count).
- R3: `src_sel` = 0 picks `ev_a_in` and `src_sel` = 1 picks `ev_b_in`; any activity on the line that is not picked leaves `count` unchanged.
- R4: Each low-to-high transition of the selected line adds exactly one to `count`, however long the line then stays high.
- R5: `count` changes only by rising by one or by going to 0; it is `COUNT_W` bits wide (default 16) and rolls over from its all-ones value to 0.
- R6: A change of `src_sel` adds nothing to `count`, even when the newly picked line is already high; the next rising edge on that line after the change is counted.
- R7: `clr` high at a clock edge sets `count` to 0 after that edge, and it takes precedence over a count enable in the same cycle.
- R8: Pulses with high and low phases of just two system clock periods each are all counted, back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses it |
| rst | input | 1 | Synchronous reset, active high |
| ev_a_in | input | 1 | External event line A, asynchronous |
| ev_b_in | input | 1 | External event line B, asynchronous |
| src_sel | input | 1 | Event source choice: 0 = line A, 1 = line B |
| clr | input | 1 | Synchronous clear of the count, active high |
| count | output | COUNT_W | Number of events counted, rolling over |

## Verification
The hardest situation to reach is a count enable and a clear arriving in the very same cycle, because the enable is buried two synchronizer stages behind the input. The stimulus raises the selected line at a falling clock edge, waits exactly two further falling edges so the enable is live, and asserts clear for that single cycle. The source switch with the new line already high is staged by raising the unpicked line first, letting it settle, and only then flipping the select. Roll-over is reached on a second, narrow instance of the block so that only a few pulses are needed.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Which external line feeds the counter
  typedef enum logic {
    SRC_LINE_A = 1'b0,
    SRC_LINE_B = 1'b1
  } evc_src_e;

  localparam int unsigned EVC_DEFAULT_W      = 16;
  localparam int unsigned EVC_DEFAULT_STAGES = 2;

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  // Stage 0 samples the raw line; later stages only copy the one before.
  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= din;
  end

  for (genvar gi = 1; gi < STAGES; gi++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[gi] <= 1'b0;
      else     chain[gi] <= chain[gi-1];
    end
  end

  assign dout = chain[LAST];

endmodule

// File: rtl/evc_edge_sel.sv
module evc_edge_sel
  import evc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic lvl_a,
  input  logic lvl_b,
  input  logic src_sel,
  output logic picked_lvl,
  output logic sel_change,
  output logic cnt_en
);

  evc_src_e sel_now;
  evc_src_e sel_q;
  logic     hist_q;

  assign sel_now    = evc_src_e'(src_sel);
  assign picked_lvl = (sel_now == SRC_LINE_B) ? lvl_b : lvl_a;
  assign sel_change = (sel_now != sel_q);

  // History always tracks the currently picked line, so in a switch cycle it
  // is reloaded with the new line's level and no false edge follows.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SRC_LINE_A;
      hist_q <= 1'b0;
    end else begin
      sel_q  <= sel_now;
      hist_q <= picked_lvl;
    end
  end

  assign cnt_en = picked_lvl && !hist_q && !sel_change;

  assert_one_shot_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> !cnt_en);

endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int unsigned COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               cnt_en,
  output logic [COUNT_W-1:0] count
);

  localparam logic [COUNT_W-1:0] ZERO = '0;

  function automatic logic [COUNT_W-1:0] bump(input logic [COUNT_W-1:0] v);
    return v + {{(COUNT_W-1){1'b0}}, 1'b1};
  endfunction

  logic [COUNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= bump(cnt_q);
  end

  assign count = cnt_q;

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == ZERO || cnt_q == $past(cnt_q) + 1'b1));

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == ZERO));

endmodule

// File: rtl/evc_event_counter.sv
module evc_event_counter
  import evc_pkg::*;
#(
  parameter int unsigned COUNT_W     = EVC_DEFAULT_W,
  parameter int unsigned SYNC_STAGES = EVC_DEFAULT_STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_a_in,
  input  logic               ev_b_in,
  input  logic               src_sel,
  input  logic               clr,
  output logic [COUNT_W-1:0] count
);

  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] sync_lines;
  logic               picked_lvl;
  logic               sel_change;
  logic               cnt_en;

  assign raw_lines = {ev_b_in, ev_a_in};

  // One synchronizer per line, ahead of any selection
  for (genvar li = 0; li < N_LINES; li++) begin : g_line
    evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw_lines[li]),
      .dout (sync_lines[li])
    );
  end

  evc_edge_sel u_edge (
    .clk        (clk),
    .rst        (rst),
    .lvl_a      (sync_lines[0]),
    .lvl_b      (sync_lines[1]),
    .src_sel    (src_sel),
    .picked_lvl (picked_lvl),
    .sel_change (sel_change),
    .cnt_en     (cnt_en)
  );

  evc_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .cnt_en (cnt_en),
    .count  (count)
  );

  assert_switch_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (src_sel != $past(src_sel)) |=> (count == $past(count) || count == '0));

  assert_enable_level_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_en |-> picked_lvl);

endmodule

// File: tb/evc_event_counter_tb.sv
module evc_event_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int WW         = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_a = 1'b0;
  logic          ev_b = 1'b0;
  logic          sel = 1'b0;
  logic          clr = 1'b0;
  logic          wclr = 1'b0;
  logic [W-1:0]  count;
  logic [WW-1:0] wcount;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evc_event_counter #(.COUNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .ev_a_in(ev_a), .ev_b_in(ev_b),
    .src_sel(sel), .clr(clr), .count(count)
  );

  // Narrow copy used only to reach roll-over quickly
  evc_event_counter #(.COUNT_W(WW)) dut_w (
    .clk(clk), .rst(rst), .ev_a_in(ev_a), .ev_b_in(ev_b),
    .src_sel(sel), .clr(wclr), .count(wcount)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit line_b, input int hi, input int lo);
    if (line_b) ev_b = 1'b1; else ev_a = 1'b1;
    idle(hi);
    if (line_b) ev_b = 1'b0; else ev_a = 1'b0;
    idle(lo);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    check("R1 count after reset", int'(count), 0);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_latency();
    int base;
    sel = 1'b0;
    idle(2);
    base = int'(count);
    ev_a = 1'b1;
    idle(2);
    check("R2 no count after two edges", int'(count), base);
    idle(1);
    check("R2 count after third edge", int'(count), base + 1);
    ev_a = 1'b0;
    idle(4);
  endtask

  task automatic t_long_pulse();
    int base = int'(count);
    pulse(1'b0, 20, 4);
    check("R4 long pulse counted once", int'(count), base + 1);
  endtask

  task automatic t_unselected();
    int base;
    sel = 1'b0;
    idle(2);
    base = int'(count);
    for (int i = 0; i < 3; i++) pulse(1'b1, 3, 3);
    check("R3 line B ignored when A picked", int'(count), base);
    sel = 1'b1;
    idle(2);
    for (int i = 0; i < 2; i++) pulse(1'b0, 3, 3);
    check("R3 line A ignored when B picked", int'(count), base);
    pulse(1'b1, 3, 4);
    check("R3 line B counted when picked", int'(count), base + 1);
  endtask

  task automatic t_switch();
    int base;
    sel = 1'b0;
    ev_b = 1'b1;
    idle(5);
    base = int'(count);
    sel = 1'b1;
    idle(5);
    check("R6 switch to high line adds nothing", int'(count), base);
    ev_b = 1'b0;
    idle(4);
    check("R6 falling after switch adds nothing", int'(count), base);
    pulse(1'b1, 3, 4);
    check("R6 next edge after switch counted", int'(count), base + 1);
    ev_a = 1'b1;
    idle(5);
    sel = 1'b0;
    idle(5);
    check("R6 switch back to high line A adds nothing", int'(count), base + 1);
    ev_a = 1'b0;
    idle(4);
  endtask

  task automatic t_clear();
    sel = 1'b0;
    pulse(1'b0, 3, 4);
    clr = 1'b1;
    idle(1);
    clr = 1'b0;
    check("R7 clear sets zero", int'(count), 0);
    pulse(1'b0, 3, 4);
    check("R7 counts again after clear", int'(count), 1);
    // Enable is live in the cycle after the second falling edge
    ev_a = 1'b1;
    idle(2);
    clr = 1'b1;
    idle(1);
    clr = 1'b0;
    check("R7 clear beats enable", int'(count), 0);
    idle(4);
    check("R7 no late count after clear", int'(count), 0);
    ev_a = 1'b0;
    idle(4);
  endtask

  task automatic t_min_pulses();
    int base;
    sel = 1'b1;
    idle(3);
    base = int'(count);
    for (int i = 0; i < 10; i++) pulse(1'b1, 2, 2);
    idle(3);
    check("R8 minimum width pulses all counted", int'(count), base + 10);
  endtask

  task automatic t_wrap();
    sel = 1'b0;
    idle(2);
    wclr = 1'b1;
    idle(1);
    wclr = 1'b0;
    for (int i = 0; i < 7; i++) pulse(1'b0, 2, 2);
    idle(3);
    check("R5 narrow counter at all-ones", int'(wcount), 7);
    pulse(1'b0, 2, 4);
    check("R5 roll-over to zero", int'(wcount), 0);
    pulse(1'b0, 2, 4);
    check("R5 counts on after roll-over", int'(wcount), 1);
  endtask

  initial begin
    idle(1);
    t_reset();
    t_latency();
    t_long_pulse();
    t_unselected();
    t_switch();
    t_clear();
    t_min_pulses();
    t_wrap();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule